// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block guards a chip against runaway software. A free-running prescaler on the crystal clock produces a slow tick. Each tick advances a small watchdog counter. If software lets that counter run past its top value, the block raises a reset request for one clock cycle. Software services the watchdog by writing to one fixed bus address. The data value of that write does not matter, so the block has no data input.

A service write clears the watchdog counter. It also clears a band of middle stages in the prescaler, so the next tick arrives at a known distance. The lowest prescaler stages keep running through the service. The watchdog can be switched off only by a purely combinational condition: a high-voltage detect on a test pin while the part is in monitor mode. There is no register bit that can disable it. After reset the watchdog is active at once. The strobe output goes to the reset controller. The bus inputs are plain control pins with no handshake: the block never stalls a write.

Top module: `wdt_top`

## Requirements
- R1: A cycle with `bus_wr` high and `bus_addr` equal to `SVC_ADDR` is a service. It returns the watchdog count to zero, so a full timeout period is needed before the next strobe.
- R2: A service sets prescaler bits `CLR_HI` down to `CLR_LO` to zero. The other prescaler bits keep their values in that cycle.
- R3: In any cycle that is not a service, the prescaler of `TICK_BIT+1` bits increments by one. A tick occurs in the cycle where the prescaler equals zero in bit `TICK_BIT` with all lower bits set, that is, where bit `TICK_BIT` is about to rise.
- R4: Each tick in an enabled, non-service cycle adds one to the `WD_W`-bit count. A tick while the count is all ones raises `wdt_rst` in the following cycle.
- R5: `wdt_rst` is high for exactly one cycle per overflow. The count wraps to zero, so with no service the strobes repeat every 2^(TICK_BIT+1+WD_W) cycles.
- R6: While `hv_det` and `mon_mode` are both high, the count is held at zero and no strobe is produced. Either signal alone has no effect.
- R7: A write to any other address, or `bus_addr` equal to `SVC_ADDR` with `bus_wr` low, leaves the count and the prescaler running as if the bus were idle.
- R8: While `rst_n` is low, `wdt_rst` is low and the prescaler and count are zero. The watchdog is enabled from the first cycle after release.
- R9: A service in the same cycle as a tick wins: the count clears and no strobe follows, even when the count was all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus address |
| hv_det | input | 1 | High-voltage level detected on the test pin |
| mon_mode | input | 1 | Part is in monitor mode |
| wdt_rst | output | 1 | One-cycle watchdog overflow reset request |

## Verification
The hardest situation to reach from the ports is a service that lands in the exact cycle when the count is all ones and a tick is due. A small bench prescaler and counter make the timeout about a thousand cycles long. The bench keeps its own cycle model of the prescaler phase, idles until that model reports the critical cycle, and then issues the service write. Band clearing is reached the same way: the bench steers the prescaler to chosen phases and services there. It then checks that the next overflow strobe arrives exactly when the cleared band predicts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Action applied to the watchdog count in one cycle
  typedef enum logic [1:0] {
    WD_KEEP  = 2'd0,
    WD_CLEAR = 2'd1,
    WD_STEP  = 2'd2
  } wd_act_e;

  // Mask with ones from bit hi down to bit lo
  function automatic logic [31:0] band_mask(input int hi, input int lo);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int TICK_BIT = 12,
  parameter int CLR_HI   = 12,
  parameter int CLR_LO   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              band_clr,
  output logic [TICK_BIT:0] pre_q
);
  localparam int PRE_W = TICK_BIT + 1;
  localparam logic [PRE_W-1:0] BAND = PRE_W'(band_mask(CLR_HI, CLR_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (band_clr) begin
      pre_q <= pre_q & ~BAND;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_BIT = 12
) (
  input  logic [TICK_BIT:0] pre_q,
  input  logic              svc,
  output logic              tick
);
  // The cycle before the tick stage rises: stage clear, all below set
  localparam logic [TICK_BIT:0] RISE_PT = {1'b0, {TICK_BIT{1'b1}}};

  always_comb begin
    tick = !svc && (pre_q == RISE_PT);
  end
endmodule

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
  import wdt_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              hv_det,
  input  logic              mon_mode,
  input  logic              tick,
  output logic              svc,
  output logic              wd_off,
  output wd_act_e           act
);
  always_comb begin
    svc    = bus_wr && (bus_addr == SVC_ADDR);
    wd_off = hv_det && mon_mode;
    if (wd_off || svc) begin
      act = WD_CLEAR;
    end else if (tick) begin
      act = WD_STEP;
    end else begin
      act = WD_KEEP;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wd_act_e         act,
  output logic [WD_W-1:0] cnt_q,
  output logic            wdt_rst
);
  localparam logic [WD_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      unique case (act)
        WD_CLEAR: begin
          cnt_q   <= '0;
          wdt_rst <= 1'b0;
        end
        WD_STEP: begin
          cnt_q   <= cnt_q + WD_W'(1);
          wdt_rst <= (cnt_q == TOP);
        end
        default: begin
          wdt_rst <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter int                TICK_BIT = 12,
  parameter int                CLR_HI   = 12,
  parameter int                CLR_LO   = 5,
  parameter int                WD_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              hv_det,
  input  logic              mon_mode,
  output logic              wdt_rst
);
  logic [TICK_BIT:0] pre_q;
  logic [WD_W-1:0]   cnt_q;
  logic              svc;
  logic              wd_off;
  logic              tick;
  wd_act_e           act;

  wdt_bus_decode #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR)
  ) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .hv_det  (hv_det),
    .mon_mode(mon_mode),
    .tick    (tick),
    .svc     (svc),
    .wd_off  (wd_off),
    .act     (act)
  );

  wdt_prescaler #(
    .TICK_BIT(TICK_BIT),
    .CLR_HI  (CLR_HI),
    .CLR_LO  (CLR_LO)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .band_clr(svc),
    .pre_q   (pre_q)
  );

  wdt_tick_gen #(
    .TICK_BIT(TICK_BIT)
  ) u_tick (
    .pre_q(pre_q),
    .svc  (svc),
    .tick (tick)
  );

  wdt_counter #(
    .WD_W(WD_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .cnt_q  (cnt_q),
    .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int TICK_BIT = 12,
  parameter int CLR_HI   = 12,
  parameter int CLR_LO   = 5,
  parameter int WD_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              svc,
  input logic              wd_off,
  input logic              tick,
  input logic [TICK_BIT:0] pre_q,
  input logic [WD_W-1:0]   cnt_q,
  input logic              wdt_rst
);
  localparam int PRE_W = TICK_BIT + 1;
  localparam logic [PRE_W-1:0] BAND = PRE_W'(band_mask(CLR_HI, CLR_LO));

  assert_svc_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt_q == '0) && !wdt_rst);

  assert_band_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> ((pre_q & BAND) == '0) && ((pre_q & ~BAND) == ($past(pre_q) & ~BAND)));

  assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !svc |=> pre_q == PRE_W'($past(pre_q) + PRE_W'(1)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wd_off) |=> cnt_q == WD_W'($past(cnt_q) + WD_W'(1)));

  assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wd_off && (cnt_q == '1)) |=> wdt_rst);

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> (cnt_q == '0) && !wdt_rst);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc && !tick && !wd_off) |=> $stable(cnt_q) && !wdt_rst);
endmodule

bind wdt_top wdt_checker #(
  .TICK_BIT(TICK_BIT),
  .CLR_HI  (CLR_HI),
  .CLR_LO  (CLR_LO),
  .WD_W    (WD_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .svc    (svc),
  .wd_off (wd_off),
  .tick   (tick),
  .pre_q  (pre_q),
  .cnt_q  (cnt_q),
  .wdt_rst(wdt_rst)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam logic [15:0] SVC = 16'hFFFF;
  localparam logic [5:0]  M_BAND = 6'b111100; // bits 5..2 with TICK_BIT=5
  localparam int FIRST_STROBE_STEP = 991;      // 16th tick: 31 + 15*64
  localparam int STROBE_PERIOD = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        hv_det = 1'b0;
  logic        mon_mode = 1'b0;
  logic        wdt_rst;

  always #4 clk = ~clk;

  wdt_top #(
    .ADDR_W(16), .SVC_ADDR(SVC), .TICK_BIT(5), .CLR_HI(5), .CLR_LO(2), .WD_W(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .hv_det(hv_det), .mon_mode(mon_mode), .wdt_rst(wdt_rst)
  );

  int   n_run = 0;
  int   n_fail = 0;
  int   n_strobe = 0;
  int   cyc = 0;
  bit   done = 0;
  logic [5:0] m_pre;
  logic [3:0] m_cnt;

  function automatic logic [5:0] next_pre(logic [5:0] p, logic s);
    return s ? (p & ~M_BAND) : p + 6'd1;
  endfunction

  function automatic logic is_tick(logic [5:0] p, logic s);
    return !s && (p == 6'h1F);
  endfunction

  task automatic check(logic act, logic expv, string tag);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_int(int act, int expv, string tag);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // One clock: drive at negedge, update model, compare after the edge
  task automatic step(logic wr, logic [15:0] a, logic hv, logic mon, string tag);
    logic s, d, t, e;
    bus_wr = wr; bus_addr = a; hv_det = hv; mon_mode = mon;
    s = wr && (a == SVC);
    d = hv && mon;
    t = is_tick(m_pre, s);
    e = !d && !s && t && (m_cnt == 4'hF);
    if (d || s) m_cnt = '0;
    else if (t) m_cnt = m_cnt + 4'd1;
    m_pre = next_pre(m_pre, s);
    @(posedge clk);
    @(negedge clk);
    check(wdt_rst, e, tag);
    if (wdt_rst) n_strobe++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; hv_det = 1'b0; mon_mode = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(wdt_rst, 1'b0, "R8 strobe low in reset");
    end
    rst_n = 1'b1;
    m_pre = '0;
    m_cnt = '0;
    n_strobe = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R8: reset, then active at once; R3/R4/R5 free run
    do_reset();
    idle(2100, "R4 free-run overflow timing");
    check_int(n_strobe, (2100 - 1 - FIRST_STROBE_STEP) / STROBE_PERIOD + 1, "R5 strobe count");

    // R8: mid-run reset restarts the full period
    idle(500, "R8 pre-reset run");
    do_reset();
    idle(FIRST_STROBE_STEP + 1, "R8 restart after reset");
    check_int(n_strobe, 1, "R8 single strobe after restart");

    // R7: non-service bus activity has no effect
    do_reset();
    for (int i = 0; i < 1000; i++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, 16'hFFFE));
      if (i % 2 == 0) step(1'b1, a, 1'b0, 1'b0, "R7 other address ignored");
      else            step(1'b0, SVC, 1'b0, 1'b0, "R7 address without write ignored");
    end
    check_int(n_strobe, 1, "R7 strobe still due");

    // R1: regular service prevents any strobe
    do_reset();
    for (int i = 0; i < 5000; i++) begin
      if (i % 700 == 699) step(1'b1, SVC, 1'b0, 1'b0, "R1 service");
      else step(1'b0, 16'h1234, 1'b0, 1'b0, "R1 serviced run");
    end
    check_int(n_strobe, 0, "R1 no strobe while serviced");

    // R2: service at chosen prescaler phases, then let it time out
    for (int k = 0; k < 4; k++) begin
      logic [5:0] target;
      target = (k == 0) ? 6'h2B : (k == 1) ? 6'h1F : (k == 2) ? 6'h3F : 6'h03;
      while (m_pre != target) step(1'b0, 16'h0000, 1'b0, 1'b0, "R2 approach phase");
      step(1'b1, SVC, 1'b0, 1'b0, "R2 band clear service");
      n_strobe = 0;
      idle(1100, "R2 timeout after band clear");
      check_int(n_strobe, 1, "R2 one strobe after band clear");
    end

    // R9: service in the overflow tick cycle
    do_reset();
    while (!(m_cnt == 4'hF && m_pre == 6'h1F)) step(1'b0, 16'h0000, 1'b0, 1'b0, "R9 approach");
    step(1'b1, SVC, 1'b0, 1'b0, "R9 service beats overflow");
    idle(100, "R9 after service");
    check_int(n_strobe, 0, "R9 no strobe");

    // R6: disable needs both signals
    do_reset();
    for (int i = 0; i < 3000; i++) step(1'b0, 16'h0000, 1'b1, 1'b1, "R6 disabled");
    check_int(n_strobe, 0, "R6 no strobe while disabled");
    n_strobe = 0;
    for (int i = 0; i < 1100; i++) step(1'b0, 16'h0000, 1'b1, 1'b0, "R6 hv alone");
    check_int(n_strobe, 1, "R6 hv alone keeps watchdog");
    n_strobe = 0;
    for (int i = 0; i < 1100; i++) step(1'b0, 16'h0000, 1'b0, 1'b1, "R6 monitor alone");
    check_int(n_strobe, 1, "R6 monitor alone keeps watchdog");

    // Random epochs mixing service rates, bus noise and disable pulses
    do_reset();
    for (int ep = 0; ep < 20; ep++) begin
      int rate;
      rate = (ep % 3 == 0) ? 0 : (ep % 3 == 1) ? 1500 : 60;
      for (int i = 0; i < 1000; i++) begin
        logic wr, hv, mon;
        logic [15:0] a;
        wr  = ($urandom_range(0, 7) == 0);
        a   = 16'($urandom_range(0, 16'hFFFE));
        if (rate != 0 && $urandom_range(0, rate - 1) == 0) begin
          wr = 1'b1; a = SVC;
        end
        hv  = ($urandom_range(0, 15) == 0);
        mon = ($urandom_range(0, 3) == 0);
        step(wr, a, hv, mon, "R4 random mix");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule